// File: doc/BRIEF.md
# Link Response Decision Controller

This block sits in a display peripheral's link layer and decides how the peripheral answers each command the host finishes sending. At the end of a host transmission the receive path raises a one-cycle completion strobe. With that strobe it presents three kinds of input: whether the host asked for the bus to be turned around, whether the command was a read, and which receive errors were found. The controller records these inputs and grants or withholds permission to execute the command. When the host handed over the bus, it then steps a packet builder through the answer, one request per cycle. The answer is read data, a plain acknowledge or a 16-bit error report, and read data may be followed by a report in the same transmission. Last comes a strobe that hands the bus back to the host.

The response depends on two things: how severe the detected errors are and whether the command is a read. Uncorrectable header errors, start-of-transmission faults, unknown command types and invalid channels all block execution and suppress read data. A corrected single-bit header error and the end-of-packet faults still let the command run, but they add an error report. All flags detected for one command are merged into one report word. The recorded flags are cleared when the report has been issued, or when a command completes without a turnaround request.

Top module: `turnaround_resp_ctrl`

## Requirements
- R1: After reset, and while no command is being answered, `exec_ok`, `send_rd`, `send_ack`, `send_err` and `bus_return` are low and `err_word` is zero.
- R2: If `turn_req` was low at the `cmd_done` strobe, none of `send_rd`, `send_ack`, `send_err` or `bus_return` is raised for that command.
- R3: A non-read command with no error flag, answered with turnaround, raises `send_ack` for one cycle, on the second cycle after the `cmd_done` edge.
- R4: A read with no error flag, answered with turnaround, raises `send_rd` for one cycle on the second cycle after the strobe, and raises neither `send_ack` nor `send_err`.
- R5: A read whose only flags are non-blocking (for example the corrected single-bit flag) raises `send_rd` and then, on the next cycle, `send_err`, with the flags in `err_word` (corrected single-bit at bit 8).
- R6: A non-read command with a corrected single-bit error (`ecc_corrected`, report bit 8) still raises `exec_ok`, and its answer is `send_err` with bit 8 set instead of an acknowledge.
- R7: The blocking errors are an uncorrectable header error (bit 9), a start-of-transmission error (bit 0), a start sync error (bit 1), an unknown type (bit 11) and an invalid channel (bit 12). If any of them is present, `exec_ok` and `send_rd` stay low and the answer is `send_err` alone.
- R8: The report word carries the flags at these positions: start error 0, start sync 1, end sync 2, escape entry 3, low-power transmit sync 4, high-speed receive timeout 5, corrected ECC 8, uncorrectable ECC 9, checksum 10, unknown type 11, bad channel 12. Bits 6, 7, 13, 14 and 15 are always zero.
- R9: When several flags are present for one command, they all appear together in a single report word, and only one report is sent.
- R10: `exec_ok` is a one-cycle pulse on the cycle after the `cmd_done` edge. It is raised exactly when no blocking error is present, whether or not a turnaround was requested.
- R11: For every command answered with turnaround, `bus_return` pulses once, on the cycle after the last packet request.
- R12: `err_word` is zero in every cycle in which `send_err` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_done | input | 1 | One-cycle strobe: host command fully received |
| turn_req | input | 1 | Host ended with a bus turnaround request (valid with `cmd_done`) |
| is_read | input | 1 | Command is a read request (valid with `cmd_done`) |
| err_sot | input | 1 | Start-of-transmission error |
| err_sot_sync | input | 1 | Start-of-transmission sync error |
| err_eot_sync | input | 1 | End-of-transmission sync error |
| err_esc_entry | input | 1 | Escape entry command error |
| err_lp_sync | input | 1 | Low-power transmit sync error |
| err_hs_timeout | input | 1 | High-speed receive timeout |
| ecc_corrected | input | 1 | Single-bit header error found and corrected |
| ecc_uncorrectable | input | 1 | Multi-bit header error, not correctable |
| err_checksum | input | 1 | Payload checksum mismatch |
| err_bad_type | input | 1 | Command type not recognized |
| err_bad_channel | input | 1 | Virtual channel not valid |
| exec_ok | output | 1 | Pulse: the command may be executed |
| send_rd | output | 1 | Pulse: builder sends the read data packet |
| send_ack | output | 1 | Pulse: builder sends a plain acknowledge |
| send_err | output | 1 | Pulse: builder sends an error report |
| err_word | output | 16 | Report word, valid with `send_err` |
| bus_return | output | 1 | Pulse: turn the bus back to the host |

## Verification
The assertions assume that `cmd_done` arrives only while the controller is idle. This reflects the fact that the host cannot finish a new command while the peripheral still holds the bus or is answering. They also assume that `turn_req`, `is_read` and the error flags are meaningful only in the strobe cycle. The bench respects both assumptions: it drives the strobe and its qualifiers together for exactly one cycle, then waits out the longest answer before the next command. It applies every combination of the eleven flags together with every read and turnaround setting.

// File: rtl/trc_pkg.sv
package trc_pkg;

  localparam int ERR_W    = 16;  // report word width, fixed by the frame
  localparam int NFLAG    = 11;  // number of detected-error inputs
  localparam int LOW_GRP  = 6;   // flags mapped one-to-one onto the low bits
  localparam int GAP      = 2;   // reserved bits skipped after the low group
  localparam int BIT_ECC1 = 8;   // corrected single-bit position

  // bits 6,7 and 13..15 are reserved
  localparam logic [ERR_W-1:0] RSV_MASK   = 16'hE0C0;
  // start error, start sync, uncorrectable ECC, bad type, bad channel
  localparam logic [ERR_W-1:0] BLOCK_MASK = 16'h1A03;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DECIDE,
    ST_RDATA,
    ST_REPORT,
    ST_ACK,
    ST_RETURN
  } seq_st_t;

  typedef struct packed {
    logic             rd;
    logic             turn;
    logic [ERR_W-1:0] word;
  } cmd_rec_t;

  // report-word position of flag input i
  function automatic int flag_pos(input int i);
    return (i < LOW_GRP) ? i : i + GAP;
  endfunction

  // any flag in the word that forbids execution
  function automatic logic blocks_exec(input logic [ERR_W-1:0] w);
    return |(w & BLOCK_MASK);
  endfunction

endpackage

// File: rtl/trc_err_pack.sv
module trc_err_pack
  import trc_pkg::*;
(
  input  logic [NFLAG-1:0] flags,
  output logic [ERR_W-1:0] word
);

  // place each flag at its report position
  for (genvar i = 0; i < NFLAG; i++) begin : g_flag
    assign word[flag_pos(i)] = flags[i];
  end

  // tie reserved positions low
  for (genvar b = 0; b < ERR_W; b++) begin : g_rsv
    if (RSV_MASK[b]) begin : g_zero
      assign word[b] = 1'b0;
    end
  end

endmodule

// File: rtl/trc_cmd_latch.sv
module trc_cmd_latch
  import trc_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     cap,
  input  cmd_rec_t cap_val,
  input  logic     clr,
  output cmd_rec_t rec
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rec <= '0;
    end else if (cap) begin
      rec <= cap_val;
    end else if (clr) begin
      rec.word <= '0;
    end
  end

endmodule

// File: rtl/trc_resp_seq.sv
module trc_resp_seq
  import trc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_done,
  input  cmd_rec_t         rec,
  output logic             exec_ok,
  output logic             send_rd,
  output logic             send_ack,
  output logic             send_err,
  output logic             bus_return,
  output logic [ERR_W-1:0] err_word,
  output logic             idle,
  output logic             clr_rec
);

  seq_st_t st, st_nx;
  logic    blk, any_err, rd_go;

  assign blk     = blocks_exec(rec.word);
  assign any_err = |rec.word;
  assign rd_go   = rec.rd & ~blk;

  always_comb begin
    st_nx = st;
    unique case (st)
      ST_IDLE:   if (cmd_done) st_nx = ST_DECIDE;
      ST_DECIDE: begin
        if (!rec.turn)   st_nx = ST_IDLE;
        else if (rd_go)  st_nx = ST_RDATA;
        else if (any_err) st_nx = ST_REPORT;
        else             st_nx = ST_ACK;
      end
      ST_RDATA:  st_nx = any_err ? ST_REPORT : ST_RETURN;
      ST_REPORT: st_nx = ST_RETURN;
      ST_ACK:    st_nx = ST_RETURN;
      ST_RETURN: st_nx = ST_IDLE;
      default:   st_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st <= ST_IDLE;
    else        st <= st_nx;
  end

  assign idle       = (st == ST_IDLE);
  assign exec_ok    = (st == ST_DECIDE) & ~blk;
  assign send_rd    = (st == ST_RDATA);
  assign send_ack   = (st == ST_ACK);
  assign send_err   = (st == ST_REPORT);
  assign bus_return = (st == ST_RETURN);
  assign err_word   = send_err ? rec.word : '0;
  assign clr_rec    = send_err | ((st == ST_DECIDE) & ~rec.turn);

endmodule

// File: rtl/turnaround_resp_ctrl.sv
module turnaround_resp_ctrl
  import trc_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cmd_done,
  input  logic        turn_req,
  input  logic        is_read,
  input  logic        err_sot,
  input  logic        err_sot_sync,
  input  logic        err_eot_sync,
  input  logic        err_esc_entry,
  input  logic        err_lp_sync,
  input  logic        err_hs_timeout,
  input  logic        ecc_corrected,
  input  logic        ecc_uncorrectable,
  input  logic        err_checksum,
  input  logic        err_bad_type,
  input  logic        err_bad_channel,
  output logic        exec_ok,
  output logic        send_rd,
  output logic        send_ack,
  output logic        send_err,
  output logic [15:0] err_word,
  output logic        bus_return
);

  logic [NFLAG-1:0] flags;
  logic [ERR_W-1:0] new_word;
  cmd_rec_t         cap_val, rec_q;
  logic             clr_rec;

  // named internal events for the checker
  logic             seq_idle;
  logic             turn_q;
  logic [ERR_W-1:0] word_q;

  assign flags = {err_bad_channel, err_bad_type, err_checksum,
                  ecc_uncorrectable, ecc_corrected, err_hs_timeout,
                  err_lp_sync, err_esc_entry, err_eot_sync,
                  err_sot_sync, err_sot};

  trc_err_pack u_pack (
    .flags (flags),
    .word  (new_word)
  );

  assign cap_val = '{rd: is_read, turn: turn_req, word: new_word};

  trc_cmd_latch u_latch (
    .clk     (clk),
    .rst_n   (rst_n),
    .cap     (cmd_done & seq_idle),
    .cap_val (cap_val),
    .clr     (clr_rec),
    .rec     (rec_q)
  );

  trc_resp_seq u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_done   (cmd_done),
    .rec        (rec_q),
    .exec_ok    (exec_ok),
    .send_rd    (send_rd),
    .send_ack   (send_ack),
    .send_err   (send_err),
    .bus_return (bus_return),
    .err_word   (err_word),
    .idle       (seq_idle),
    .clr_rec    (clr_rec)
  );

  assign turn_q = rec_q.turn;
  assign word_q = rec_q.word;

endmodule

// File: rtl/trc_chk.sv
module trc_chk
  import trc_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             cmd_done,
  input logic             exec_ok,
  input logic             send_rd,
  input logic             send_ack,
  input logic             send_err,
  input logic [ERR_W-1:0] err_word,
  input logic             bus_return,
  input logic             seq_idle,
  input logic             turn_q,
  input logic [ERR_W-1:0] word_q
);

  // input assumption: a new command completes only while idle
  a_r10_cmd_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_done |-> seq_idle);

  a_r10_exec_after_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    exec_ok |-> $past(cmd_done));

  a_r7_rd_needs_permit: assert property (@(posedge clk) disable iff (!rst_n)
    send_rd |-> $past(exec_ok));

  a_r3_ack_needs_permit: assert property (@(posedge clk) disable iff (!rst_n)
    send_ack |-> $past(exec_ok));

  a_r5_rd_then_report: assert property (@(posedge clk) disable iff (!rst_n)
    (send_rd && (word_q != '0)) |=> send_err);

  a_r2_turn_required: assert property (@(posedge clk) disable iff (!rst_n)
    (send_rd || send_ack || send_err || bus_return) |-> turn_q);

  a_r8_rsv_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (err_word & RSV_MASK) == '0);

  a_r9_one_request: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({send_rd, send_ack, send_err, bus_return}));

  a_r11_return_follows_pkt: assert property (@(posedge clk) disable iff (!rst_n)
    bus_return |-> $past(send_rd || send_ack || send_err));

  a_r11_return_single: assert property (@(posedge clk) disable iff (!rst_n)
    bus_return |=> !bus_return);

  a_r12_word_only_in_report: assert property (@(posedge clk) disable iff (!rst_n)
    !send_err |-> (err_word == '0));

endmodule

bind turnaround_resp_ctrl trc_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cmd_done   (cmd_done),
  .exec_ok    (exec_ok),
  .send_rd    (send_rd),
  .send_ack   (send_ack),
  .send_err   (send_err),
  .err_word   (err_word),
  .bus_return (bus_return),
  .seq_idle   (seq_idle),
  .turn_q     (turn_q),
  .word_q     (word_q)
);

// File: tb/tb_turnaround_resp_ctrl.sv
`timescale 1ns/1ps
module tb_turnaround_resp_ctrl;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_done = 1'b0;
  logic        turn_req = 1'b0;
  logic        is_read = 1'b0;
  logic [10:0] fl = '0;
  logic        exec_ok, send_rd, send_ack, send_err, bus_return;
  logic [15:0] err_word;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  turnaround_resp_ctrl dut (
    .clk               (clk),
    .rst_n             (rst_n),
    .cmd_done          (cmd_done),
    .turn_req          (turn_req),
    .is_read           (is_read),
    .err_sot           (fl[0]),
    .err_sot_sync      (fl[1]),
    .err_eot_sync      (fl[2]),
    .err_esc_entry     (fl[3]),
    .err_lp_sync       (fl[4]),
    .err_hs_timeout    (fl[5]),
    .ecc_corrected     (fl[6]),
    .ecc_uncorrectable (fl[7]),
    .err_checksum      (fl[8]),
    .err_bad_type      (fl[9]),
    .err_bad_channel   (fl[10]),
    .exec_ok           (exec_ok),
    .send_rd           (send_rd),
    .send_ack          (send_ack),
    .send_err          (send_err),
    .err_word          (err_word),
    .bus_return        (bus_return)
  );

  // observed vector: {exec, rd, ack, err, ret, word}
  function automatic logic [20:0] obs();
    return {exec_ok, send_rd, send_ack, send_err, bus_return, err_word};
  endfunction

  task automatic check(input string tag, input logic [20:0] got,
                       input logic [20:0] exp, input string ctx);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s %s got=%h exp=%h", tag, ctx, got, exp);
    end
  endtask

  task automatic run_one(input logic [10:0] f, input logic rd, input logic tn);
    logic [15:0] w;
    logic        blk, anye;
    logic [20:0] ex [5];
    string       tg [5];
    int          k;
    string       ctx;
    // report positions restated as a concatenation (R8)
    w    = {3'b000, f[10:6], 2'b00, f[5:0]};
    blk  = f[0] | f[1] | f[7] | f[9] | f[10];
    anye = (f != 11'd0);
    for (int i = 0; i < 5; i++) begin
      ex[i] = '0;
      tg[i] = tn ? "R12" : "R2";
    end
    ex[0] = {~blk, 20'd0};
    tg[0] = "R10";
    k = 1;
    if (tn) begin
      if (rd && !blk) begin
        ex[k] = {5'b01000, 16'h0};
        tg[k] = anye ? "R5" : "R4";
        k++;
      end
      if (anye) begin
        ex[k] = {5'b00010, w};
        if (blk)                         tg[k] = "R7";
        else if (f == 11'h040)           tg[k] = rd ? "R5" : "R6";
        else if ($countones(f) > 1)      tg[k] = "R9";
        else                             tg[k] = "R8";
        k++;
      end else if (!rd) begin
        ex[k] = {5'b00100, 16'h0};
        tg[k] = "R3";
        k++;
      end
      ex[k] = {5'b00001, 16'h0};
      tg[k] = "R11";
    end
    cmd_done = 1'b1;
    turn_req = tn;
    is_read  = rd;
    fl       = f;
    @(negedge clk);
    cmd_done = 1'b0;
    turn_req = 1'b0;
    is_read  = 1'b0;
    fl       = '0;
    for (int c = 0; c < 5; c++) begin
      if (c > 0) @(negedge clk);
      ctx = $sformatf("f=%h rd=%0d turn=%0d cyc=%0d", f, rd, tn, c);
      check(tg[c], obs(), ex[c], ctx);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1", obs(), 21'd0, "in reset");
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", obs(), 21'd0, "after reset");
    for (int t = 0; t < 2; t++) begin
      for (int r = 0; r < 2; r++) begin
        for (int f = 0; f < 2048; f++) begin
          run_one(11'(f), r[0], t[0]);
        end
      end
    end
    @(negedge clk);
    check("R1", obs(), 21'd0, "idle at end");
    done = 1'b1;
  end

  initial begin
    for (int i = 0; i < 150000; i++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired got=running exp=finished");
    end
    $display("[TB] %0d tests run, %0d failed", n_chk, n_bad);
    $finish;
  end

endmodule